// File: doc/BRIEF.md
# Broadcast Multiply-Accumulate Array for Serially Arriving Inputs

This block computes a fully connected layer whose inputs arrive one element per cycle. It is built for layers with many inputs and relatively few outputs. Every accepted input element goes to all output lanes in the same cycle. Each lane multiplies the element by a weight taken from its own local weight store. The weight is selected by the position of the element within the current vector. The lane then adds the product to its private accumulator. There is one lane per output. Each lane's weight store holds one word per input position.

A vector ends when an element is flagged as last, or when the element at the final storable position arrives. In the cycle after that element, every lane holds its complete inner product and a one-cycle completion pulse is raised. The results are presented in parallel on a flat bus and stay unchanged until the first element of the next vector is accepted.

Weights are loaded through a simple write port that addresses a lane and a word. A start pulse drops any partially accumulated vector, so that the next element is treated as position zero. Activation functions are applied elsewhere.

Top module: `tmi_mac_array`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `done` is low and every lane result is zero.
- R2: For a vector of elements x0..x(n-1), where the index is the arrival order counted from 0 and skips cycles with `in_valid` low, lane j reports the sum over k of w[j][k]·xk. Both inputs and weights are two's-complement signed, and the result is the two's-complement signed lane field `res_flat[j*ACC_W +: ACC_W]`.
- R3: `done` is high for exactly one cycle: the cycle after the final element of a vector is accepted. Back-to-back vectors give back-to-back pulses, and `done` never rises at any other time.
- R4: Lane results do not change in any cycle that follows a cycle without an accepted element. This holds across idle gaps, weight writes and start pulses.
- R5: Cycles with `in_valid` low between elements of a vector pause the accumulation without changing the index or the partial sums.
- R6: A `start` pulse sets the index to 0 and marks the next accepted element as the first of a new vector, which discards the partial sums. If `start` and `in_valid` are high together, that element is index 0 of the new vector.
- R7: An element accepted at index DEPTH-1 ends the vector even when `in_last` is low. The next element begins a new vector at index 0.
- R8: When `wr_en` is high, word `wr_addr` of lane `wr_lane` is written with `wr_data` at the clock edge. An element accepted in the same cycle uses that word's previous content, and later elements use the new one.
- R9: The accumulator width is 2·DW+log2(DEPTH) bits, so a full-length vector of the most negative input times the most negative weight is reported exactly, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Weight write strobe |
| wr_lane | input | LW | Lane whose weight store is written |
| wr_addr | input | AW | Word (input position) written |
| wr_data | input | DW | Signed weight value |
| start | input | 1 | Abandon the current vector; next element is index 0 |
| in_valid | input | 1 | Input element present this cycle |
| in_data | input | DW | Signed input element |
| in_last | input | 1 | Element is the final one of its vector |
| done | output | 1 | One-cycle pulse: results complete |
| res_flat | output | LANES*ACC_W | Lane results, lane j at bits j*ACC_W upward |

## Verification
The bench builds the array with 4 lanes, 8 words per lane and 8-bit data, which gives a 19-bit accumulator. With only eight positions, a vector can reach the final storable index within a few cycles. This makes the implicit end of a vector at DEPTH-1 easy to exercise, and it allows the all-most-negative full-length vector to test the accumulator width in a short run. Four lanes are enough to show that a write to one lane's store leaves the other lanes alone, and that every lane takes the same broadcast element.

// File: rtl/tmi_pkg.sv
// Shared sizing helpers for the broadcast multiply-accumulate array.
package tmi_pkg;

    // Accumulator width that holds DEPTH products of two DW-bit signed values without wrap
    function automatic int acc_width(input int dw, input int depth);
        return 2 * dw + $clog2(depth);
    endfunction

endpackage

// File: rtl/tmi_weight_mem.sv
// Per-lane weight store: one signed word per input position.
// Synchronous write, combinational read, so a word written in the same
// cycle as it is read is seen only from the next cycle on.
// Assumes DEPTH >= 2. The contents are not reset.
module tmi_weight_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [DW-1:0] wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic signed [DW-1:0] rd_data
);

    logic signed [DW-1:0] words [DEPTH];

    // Store a weight word on a write strobe
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Present the word for the current input position
    assign rd_data = words[rd_addr];

endmodule

// File: rtl/tmi_index_ctrl.sv
// Sequencer for the input stream. It tracks the arrival position of the
// next element, flags the first element of each vector, and raises a
// one-cycle completion pulse after the final element.
// A vector ends on in_last or at position DEPTH-1. start forces position 0.
// Assumes DEPTH >= 2.
module tmi_index_ctrl #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    input  logic          in_last,
    output logic [AW-1:0] cur_idx,
    output logic          cur_first,
    output logic          done
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [AW-1:0] idx_q;
    logic          first_q;
    logic          ends_here;

    // Effective position and first flag, with start taking precedence
    always_comb begin
        cur_idx   = start ? '0 : idx_q;
        cur_first = start | first_q;
        ends_here = in_last | (cur_idx == LAST_IDX);
    end

    // Advance the position, rearm the first flag and form the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            first_q <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= in_valid & ends_here;
            if (in_valid) begin
                idx_q   <= ends_here ? '0 : cur_idx + AW'(1);
                first_q <= ends_here;
            end else if (start) begin
                idx_q   <= '0;
                first_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmi_mac_lane.sv
// One output lane: multiplies the broadcast element by this lane's weight
// and accumulates the product. The first element of a vector overwrites
// the accumulator, which clears the previous result.
// Assumes ACC_W > 2*DW.
module tmi_mac_lane #(
    parameter int DW    = 8,
    parameter int ACC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic                    first,
    input  logic signed [DW-1:0]    x,
    input  logic signed [DW-1:0]    w,
    output logic signed [ACC_W-1:0] acc
);

    localparam int PW = 2 * DW;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext;

    // Signed product, sign-extended to the accumulator width
    always_comb begin
        prod     = x * w;
        prod_ext = {{(ACC_W - PW){prod[PW-1]}}, prod};
    end

    // Load on the first element, accumulate on the rest, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (fire) begin
            acc <= first ? prod_ext : acc + prod_ext;
        end
    end

endmodule

// File: rtl/tmi_mac_array.sv
// Fully connected layer for serially arriving inputs. Each accepted element
// is broadcast to LANES multiply-accumulate lanes. Each lane reads its weight
// for the element's arrival position from its own DEPTH-word store.
// All lane results are complete, and done pulses, one cycle after the final
// element. The results then hold until the next vector's first element.
// Assumes LANES >= 2 and DEPTH >= 2.
module tmi_mac_array #(
    parameter int LANES = 16,
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    parameter int LW    = $clog2(LANES),
    parameter int AW    = $clog2(DEPTH),
    parameter int ACC_W = tmi_pkg::acc_width(DW, DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [LW-1:0]          wr_lane,
    input  logic [AW-1:0]          wr_addr,
    input  logic signed [DW-1:0]   wr_data,
    input  logic                   start,
    input  logic                   in_valid,
    input  logic signed [DW-1:0]   in_data,
    input  logic                   in_last,
    output logic                   done,
    output logic [LANES*ACC_W-1:0] res_flat
);

    logic [AW-1:0] cur_idx;
    logic          cur_first;

    tmi_index_ctrl #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .cur_idx   (cur_idx),
        .cur_first (cur_first),
        .done      (done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic                    lane_we;
        logic signed [DW-1:0]    lane_w;
        logic signed [ACC_W-1:0] lane_acc;

        // Route the write strobe to the addressed lane only
        assign lane_we = wr_en && (wr_lane == LW'(g));

        tmi_weight_mem #(
            .DW    (DW),
            .DEPTH (DEPTH),
            .AW    (AW)
        ) u_mem (
            .clk     (clk),
            .wr_en   (lane_we),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (cur_idx),
            .rd_data (lane_w)
        );

        tmi_mac_lane #(
            .DW    (DW),
            .ACC_W (ACC_W)
        ) u_mac (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (in_valid),
            .first (cur_first),
            .x     (in_data),
            .w     (lane_w),
            .acc   (lane_acc)
        );

        // Place this lane's result in its field of the flat bus
        assign res_flat[g*ACC_W +: ACC_W] = lane_acc;
    end

endmodule

// File: rtl/tmi_mac_array_chk.sv
// Property checker for tmi_mac_array. It watches the ports and the
// sequencer's effective position. It is attached to every instance by bind.
module tmi_mac_array_chk #(
    parameter int LANES = 16,
    parameter int DEPTH = 128,
    parameter int AW    = 7,
    parameter int ACC_W = 23
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   in_valid,
    input logic                   in_last,
    input logic                   done,
    input logic [LANES*ACC_W-1:0] res_flat,
    input logic [AW-1:0]          cur_idx
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && res_flat == '0));

    // R3
    done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && in_last)) |-> done);

    // R3
    done_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid));

    // R4
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(res_flat));

    // R6
    start_rewinds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !in_valid) |=> (cur_idx == '0));

    // R7
    depth_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(cur_idx) == AW'(DEPTH - 1)) |-> done);

endmodule

bind tmi_mac_array tmi_mac_array_chk #(
    .LANES (LANES),
    .DEPTH (DEPTH),
    .AW    (AW),
    .ACC_W (ACC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_last  (in_last),
    .done     (done),
    .res_flat (res_flat),
    .cur_idx  (cur_idx)
);

// File: tb/tmi_mac_array_bench.sv
// Scoreboard bench: the driver computes the expected lane sums from its own
// weight model and queues them. The monitor compares them on each done pulse.
module tmi_mac_array_bench;

    localparam int L     = 4;
    localparam int D     = 8;
    localparam int DW    = 8;
    localparam int LW    = 2;
    localparam int AW    = 3;
    localparam int ACC_W = 19;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst_n, wr_en, start, in_valid, in_last, done;
    logic [LW-1:0]        wr_lane;
    logic [AW-1:0]        wr_addr;
    logic signed [DW-1:0] wr_data, in_data;
    logic [L*ACC_W-1:0]   res_flat;

    tmi_mac_array #(
        .LANES (L),
        .DEPTH (D),
        .DW    (DW)
    ) u_tmi_mac_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_lane  (wr_lane),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .start    (start),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .done     (done),
        .res_flat (res_flat)
    );

    int     total = 0;
    int     bad   = 0;
    int     wm [L][D];
    longint expq[$];
    string  tagq[$];
    longint last_exp [L];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint lane_res(input int l);
        logic signed [ACC_W-1:0] f;
        f = res_flat[l*ACC_W +: ACC_W];
        return longint'(f);
    endfunction

    // Monitor: pop one expected vector per done pulse and compare every lane
    always @(negedge clk) begin
        if (rst_n === 1'b1 && done === 1'b1) begin
            if (tagq.size() == 0) begin
                chk(1'b0, "R3 done without a finished vector", 1, 0);
            end else begin
                string t;
                t = tagq.pop_front();
                for (int l = 0; l < L; l++) begin
                    longint e;
                    e = expq.pop_front();
                    chk(lane_res(l) == e, t, lane_res(l), e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 0; start = 0; in_valid = 0; in_last = 0;
        end
    endtask

    task automatic wload(input int l, input int a, input int v);
        @(negedge clk);
        start = 0; in_valid = 0; in_last = 0;
        wr_en = 1; wr_lane = LW'(l); wr_addr = AW'(a); wr_data = DW'(v);
        wm[l][a] = v;
    endtask

    // Driver: feed n elements, queue the expected sums if the vector ends
    task automatic send_vec(input string tag, input int n, input int vals[],
                            input int gap, input bit use_last, input bit start_first);
        longint acc [L];
        bit     ends;
        ends = use_last || (n == D);
        for (int l = 0; l < L; l++) begin
            acc[l] = 0;
            for (int k = 0; k < n; k++) acc[l] += longint'(wm[l][k]) * longint'(vals[k]);
        end
        for (int k = 0; k < n; k++) begin
            if (gap > 0 && (k % 2) == 1) idle(gap);
            @(negedge clk);
            wr_en    = 0;
            in_valid = 1;
            in_data  = DW'(vals[k]);
            in_last  = use_last && (k == n - 1);
            start    = start_first && (k == 0);
            if (k == n - 1 && ends) begin
                tagq.push_back(tag);
                for (int l = 0; l < L; l++) begin
                    expq.push_back(acc[l]);
                    last_exp[l] = acc[l];
                end
            end
        end
    endtask

    function automatic void mkvals(ref int v[], input int n);
        v = new[n];
        for (int k = 0; k < n; k++) v[k] = int'($urandom_range(0, 255)) - 128;
    endfunction

    initial begin
        #(8 * 20000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v[];
        rst_n = 0; wr_en = 0; start = 0; in_valid = 0; in_last = 0;
        wr_lane = '0; wr_addr = '0; wr_data = '0; in_data = '0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(done == 1'b0, "R1 done in reset", longint'(done), 0);
        chk(res_flat == '0, "R1 results in reset", longint'(res_flat != '0), 0);
        rst_n = 1;
        @(negedge clk);
        chk(done == 1'b0 && res_flat == '0, "R1 state after reset", longint'(done), 0);

        for (int l = 0; l < L; l++)
            for (int a = 0; a < D; a++) wload(l, a, ((l * 37 + a * 53) % 200) - 100);
        idle(1);

        // R2: full-length and short vectors with last
        v = new[D];
        for (int k = 0; k < D; k++) v[k] = k + 1;
        send_vec("R2 full vector", D, v, 0, 1, 0);
        mkvals(v, 5);
        send_vec("R2 short vector", 5, v, 0, 1, 0);
        // R3: back-to-back single-element vectors
        mkvals(v, 1);
        send_vec("R3 back-to-back A", 1, v, 0, 1, 0);
        mkvals(v, 1);
        send_vec("R3 back-to-back B", 1, v, 0, 1, 0);
        idle(2);

        // R5: gaps between elements
        mkvals(v, 6);
        send_vec("R5 gapped vector", 6, v, 3, 1, 0);
        idle(3);

        // R4: results hold across idle, weight write and start
        wload(1, 0, 77);
        idle(1);
        @(negedge clk); start = 1;
        idle(3);
        for (int l = 0; l < L; l++)
            chk(lane_res(l) == last_exp[l], "R4 results held", lane_res(l), last_exp[l]);

        // R6: start alone discards a partial vector
        mkvals(v, 3);
        send_vec("R6 partial", 3, v, 0, 0, 0);
        idle(1);
        @(negedge clk); start = 1;
        idle(1);
        mkvals(v, 5);
        send_vec("R6 after start pulse", 5, v, 0, 1, 0);
        // R6: start together with the first element
        mkvals(v, 2);
        send_vec("R6 partial two", 2, v, 0, 0, 0);
        mkvals(v, 4);
        send_vec("R6 start with element", 4, v, 0, 1, 1);
        idle(2);

        // R7: vector ends at position DEPTH-1 without last, next starts fresh
        mkvals(v, D);
        send_vec("R7 implicit end", D, v, 0, 0, 0);
        mkvals(v, 3);
        send_vec("R7 fresh vector after", 3, v, 0, 1, 0);
        idle(2);

        // R8: write in the same cycle as the element that reads that word
        begin
            longint e [L];
            for (int l = 0; l < L; l++) e[l] = longint'(wm[l][0]) * 5 + longint'(wm[l][1]) * (-7);
            @(negedge clk);
            in_valid = 1; in_data = 5; in_last = 0; start = 0;
            wr_en = 1; wr_lane = 0; wr_addr = 0; wr_data = 99;
            @(negedge clk);
            wr_en = 0; in_data = -7; in_last = 1;
            tagq.push_back("R8 old word used in write cycle");
            for (int l = 0; l < L; l++) expq.push_back(e[l]);
            wm[0][0] = 99;
        end
        v = new[1]; v[0] = 3;
        send_vec("R8 new word used later", 1, v, 0, 1, 0);
        idle(2);

        // R9: extreme values over a full-length vector
        for (int l = 0; l < L; l++)
            for (int a = 0; a < D; a++) wload(l, a, -128);
        idle(1);
        v = new[D];
        for (int k = 0; k < D; k++) v[k] = -128;
        send_vec("R9 extreme sum", D, v, 0, 1, 0);
        idle(4);

        chk(tagq.size() == 0, "R3 every finished vector pulsed done", tagq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule